// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls an eight-pin general-purpose I/O port through three register views on a simple register bus. One register sets the direction of each pin. A second register gives the value a pin drives when it is an output. The same bit turns on a weak pull-up when the pin is an input. A third view returns the pad levels, which reach it through a two-stage synchronizer on the I/O clock. The pad-facing outputs are a tri-state enable, a drive value and a pull-up enable for each pin.

Two inputs are shared by all ports. A pull-up kill input turns every pull-up off. A sleep input holds the synchronizer input at a fixed low level. Writing ones to the pin-view address flips the matching output bits, so software can toggle pins without a read-modify-write. Reset clears the direction and output registers asynchronously. The pads are therefore tri-stated with pull-ups off even while no clock runs.

The design has no state sequencer. Its state is the direction register, the output register and the synchronizer pipeline. Every access completes in a single cycle.

Top module: `gpio_port_ctrl`

## Requirements
- R1: The register selector `reg_sel` decodes as 2'b00 pin view, 2'b01 direction, 2'b10 output/pull-up, and 2'b11 unused. A write to 2'b11 changes no register, and a read of 2'b11 returns zero.
- R2: A write with `reg_sel`=2'b01 loads all eight bits of `wr_data` into the direction register at that clock edge. `pad_oe` equals the direction register bit for bit.
- R3: A write with `reg_sel`=2'b10 loads all eight bits of `wr_data` into the output register at that clock edge. `pad_out` equals the output register.
- R4: `pad_pu[n]` is 1 only when direction bit n is 0 and output bit n is 1. It is 0 whenever the pin is an output or its output bit is 0.
- R5: While `pu_kill` is 1, every bit of `pad_pu` is 0, whatever the register contents.
- R6: A write with `reg_sel`=2'b00 inverts each output-register bit whose `wr_data` bit is 1. Output-register bits whose `wr_data` bit is 0 are left unchanged.
- R7: `rst_n` low clears the direction register, the output register and the synchronizer at once, with no clock edge. `pad_oe` and `pad_pu` are then all zero.
- R8: A change on `pad_in` shows up in the pin view on the second rising clock edge after it, and not on the first.
- R9: While `sleep` is 1, the synchronizer captures all zeros in place of `pad_in`.
- R10: While `rd_en` is 1, `rd_data` shows the selected view in the same cycle. The direction and output views return the stored bits. The pin view returns the synchronized pad levels whatever the direction. While `rd_en` is 0, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register view selector |
| wr_data | input | 8 | Write data, all pins at once |
| rd_data | output | 8 | Read data, combinational |
| pu_kill | input | 1 | Global pull-up disable |
| sleep | input | 1 | Sleep control, gates the pad input path |
| pad_in | input | 8 | Pad levels |
| pad_oe | output | 8 | Output driver enable per pin |
| pad_out | output | 8 | Drive value per pin |
| pad_pu | output | 8 | Pull-up enable per pin |

## Verification
Register writes take effect at the clock edge that samples them, so `pad_oe`, `pad_out` and `pad_pu` are compared at the falling edge that follows. Reads are combinational and are compared in the same half-cycle as the strobe. A pad change goes through two flip-flops. The bench changes `pad_in` just after a rising edge and expects the old level after the first edge and the new level after the second. A behavioural model updated on every rising edge predicts all outputs, and they are compared on every falling edge. The reset case is checked with the clock stopped.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        REG_PIN  = 2'b00,
        REG_DIR  = 2'b01,
        REG_OUT  = 2'b10,
        REG_NONE = 2'b11
    } gpio_reg_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  gpio_reg_e    sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);
    // Direction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_en && sel == REG_DIR)
            dir_q <= wdata;
    end

    // Output / pull-up register: load or toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else if (wr_en && sel == REG_OUT)
            out_q <= wdata;
        else if (wr_en && sel == REG_PIN)
            out_q <= out_q ^ wdata;
    end

    assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_DIR) |=> dir_q == $past(wdata));

    assert_unused_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_NONE) |=> ($stable(dir_q) && $stable(out_q)));

    assert_toggle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_PIN && wdata == '0) |=> $stable(out_q));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level_o
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] gated;
    logic [W-1:0] stage_q [STAGES];

    assign gated = sleep ? '0 : pad_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= gated;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign level_o = stage_q[LAST];

    assert_sleep_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> stage_q[0] == '0);

    assert_sync_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> level_o == $past(stage_q[LAST-1]));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] out_q,
    input  logic         pu_kill,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    for (genvar n = 0; n < W; n++) begin : g_pin
        assign pad_oe[n]  = dir_q[n];
        assign pad_out[n] = out_q[n];
        assign pad_pu[n]  = !pu_kill && !dir_q[n] && out_q[n];
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int N_PINS  = 8,
    parameter int N_SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        reg_sel,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] rd_data,
    input  logic              pu_kill,
    input  logic              sleep,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_pu
);
    gpio_reg_e         sel;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] out_q;
    logic [N_PINS-1:0] pin_lvl;

    assign sel = gpio_reg_e'(reg_sel);

    gpio_port_regs #(.W(N_PINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wr_data),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    gpio_pin_sync #(.W(N_PINS), .STAGES(N_SYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .pad_in  (pad_in),
        .level_o (pin_lvl)
    );

    gpio_pad_drive #(.W(N_PINS)) u_pad (
        .dir_q   (dir_q),
        .out_q   (out_q),
        .pu_kill (pu_kill),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .pad_pu  (pad_pu)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                REG_PIN:  rd_data = pin_lvl;
                REG_DIR:  rd_data = dir_q;
                REG_OUT:  rd_data = out_q;
                default:  rd_data = '0;
            endcase
        end
    end

    assert_pull_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pu_kill |-> pad_pu == '0);

    assert_pu_vs_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    assert_out_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_OUT) |=> pad_out == $past(wr_data));
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, pu_kill = 1'b0, sleep = 1'b0;
    logic [1:0] reg_sel = 2'b00;
    logic [7:0] wr_data = '0, pad_in = '0;
    logic [7:0] rd_data, pad_oe, pad_out, pad_pu;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 if (clk_run) clk = ~clk;

    gpio_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .pu_kill(pu_kill), .sleep(sleep), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // Behavioural reference
    logic [7:0] m_dir = '0, m_out = '0;
    logic [7:0] m_q[$] = '{8'h00, 8'h00};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_q = '{8'h00, 8'h00};
        end else begin
            m_q.push_back(sleep ? 8'h00 : pad_in);
            void'(m_q.pop_front());
            if (wr_en) begin
                if (reg_sel == 2'b01) m_dir = wr_data;
                else if (reg_sel == 2'b10) m_out = wr_data;
                else if (reg_sel == 2'b00) m_out = m_out ^ wr_data;
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        if (!rd_en) return 8'h00;
        case (reg_sel)
            2'b00:   return m_q[0];
            2'b01:   return m_dir;
            2'b10:   return m_out;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        check("R2 pad_oe", pad_oe, m_dir);
        check("R3 pad_out", pad_out, m_out);
        check("R4 R5 pad_pu", pad_pu, pu_kill ? 8'h00 : (~m_dir & m_out));
        check("R10 rd_data", rd_data, exp_rd());
    end

    task automatic drive(logic w, logic r, logic [1:0] s, logic [7:0] d);
        @(posedge clk); #1;
        wr_en = w; rd_en = r; reg_sel = s; wr_data = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 2'b00, 8'h00);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        #9 rst_n = 1'b1;
        #1;
        // R7 reset state
        check("R7 oe after reset", pad_oe, 8'h00);
        check("R7 pu after reset", pad_pu, 8'h00);

        drive(1'b1, 1'b0, 2'b01, 8'hF0);              // R2
        drive(1'b1, 1'b0, 2'b10, 8'h3C);              // R3, R4
        drive(1'b0, 1'b1, 2'b01, 8'h00);              // R10 read dir
        drive(1'b0, 1'b1, 2'b10, 8'h00);              // R10 read out
        drive(1'b1, 1'b0, 2'b00, 8'h81);              // R6 toggle
        drive(1'b1, 1'b0, 2'b00, 8'h00);              // R6 zeros
        drive(1'b1, 1'b0, 2'b11, 8'hFF);              // R1 unused write
        drive(1'b0, 1'b1, 2'b11, 8'h00);              // R1 unused read
        @(negedge clk);
        check("R1 unused read zero", rd_data, 8'h00);
        check("R6 toggle result", pad_out, 8'hBD);
        drive(1'b0, 1'b0, 2'b00, 8'h00);
        pu_kill = 1'b1;                                // R5
        @(negedge clk);
        check("R5 pull-ups killed", pad_pu, 8'h00);
        drive(1'b0, 1'b0, 2'b00, 8'h00);
        pu_kill = 1'b0;

        // R8 latency, read pin view with outputs enabled on upper half
        drive(1'b0, 1'b1, 2'b00, 8'h00);
        idle(0);
        @(posedge clk); #1;
        pad_in = 8'hA5;
        @(negedge clk);
        @(negedge clk);
        check("R8 not after first edge", rd_data, 8'h00);
        @(negedge clk);
        check("R8 after second edge", rd_data, 8'hA5);

        // R9 sleep gating
        @(posedge clk); #1;
        sleep = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R9 sleep forces zero", rd_data, 8'h00);
        @(posedge clk); #1;
        sleep = 1'b0; pad_in = 8'h5A;
        idle(4);
        drive(1'b1, 1'b0, 2'b01, 8'h0F);
        drive(1'b1, 1'b0, 2'b10, 8'hFF);
        drive(1'b0, 1'b1, 2'b00, 8'h00);
        @(negedge clk);
        check("R10 pin view regardless of dir", rd_data, 8'h5A);
        check("R4 pull-ups on inputs", pad_pu, 8'hF0);
        idle(2);

        // R7 asynchronous reset with the clock stopped
        @(negedge clk);
        clk_run = 1'b0;
        #3 rst_n = 1'b0;
        #3;
        check("R7 async oe clear", pad_oe, 8'h00);
        check("R7 async pu clear", pad_pu, 8'h00);
        check("R7 async out clear", pad_out, 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule